// File: doc/BRIEF.md
# Two-Source Interrupt Sequencer

This block is the interrupt control logic for a small 4-bit controller core. It serves two sources: an external pin and a timer underflow strobe. Each source has a pending flag and an enable bit. One global enable flag gates both sources. A 4-bit control register is written from the accumulator and read back to it. Besides the two enables, that register holds the timer run bit and the select bit for the shared timer output pin.

The block counts time in machine cycles of four clock phases. It samples instruction-level controls on the last phase of each machine cycle. These controls are enable-interrupt, disable-interrupt, the skip tests, and the flag that says the current instruction is longer than one cycle. Once the three gating conditions hold together, a vector request goes to the instruction sequencer after two or three machine cycles. The request carries a source identifier. Accepting the request clears the serviced flag and the global enable. The skip-test results tell software whether a flag is pending, but only for a source whose interrupt is disabled.

Top module: `irq_seq`

## Requirements
- R1: After reset the control readback is 0000. `tmr_run`, `tout_sel`, `vec_req`, `skip_ext` and `skip_tmr` are all 0.
- R2: A `ctrl_wr` strobe loads `acc_wdata` into the control register, and `ctrl_rdata` returns it. Bit 0 enables the external source and bit 1 enables the timer source. Bit 2 drives `tmr_run` and bit 3 drives `tout_sel`.
- R3: A vector request is raised only while the global enable, a source's enable bit and that source's flag are all 1. There is never a vector otherwise.
- R4: The cycle-end edge is the clock edge that ends phase 3. Let E be the first cycle-end edge on which the conditions of R3 hold. `vec_req` is high for the clock that starts L cycle-end edges after E. L is 2 when `multi_cyc` is 0 at E and 3 when it is 1.
- R5: An `ei_exec` sampled at a cycle-end edge sets the global enable at the next cycle-end edge. A `di_exec` sampled at a cycle-end edge clears the global enable and cancels a pending enable.
- R6: `vec_req` is a one-clock pulse. In that clock `vec_src` is 0 for the external source and 1 for the timer. The serviced flag and the global enable are both cleared.
- R7: If both sources are enabled and pending when the request fires, the external source is served. The timer flag stays pending.
- R8: With active-high polarity, the external flag is set only if `ext_pin` stays high for at least 5 consecutive clocks. A shorter pulse has no effect.
- R9: `skip_ext` and `skip_tmr` show a pending flag only while that source's enable bit is 0. While the source is enabled they stay 0.
- R10: A `tst_ext` or `tst_tmr` strobe at a cycle-end edge clears that flag only when its skip result is 1. While the source is enabled the strobe leaves the flag unchanged.
- R11: If the conditions of R3 are withdrawn during the wait, for example by `di_exec`, no vector is raised and the flag stays pending.
- R12: A one-clock `tmr_uf` strobe sets the timer flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock, one phase per period |
| rst_n | input | 1 | Active-low synchronous reset |
| ext_pin | input | 1 | External interrupt pin, asynchronous |
| tmr_uf | input | 1 | Timer underflow strobe, one clock |
| multi_cyc | input | 1 | Current instruction is longer than one machine cycle |
| ei_exec | input | 1 | Enable-interrupt instruction, sampled at cycle end |
| di_exec | input | 1 | Disable-interrupt instruction, sampled at cycle end |
| tst_ext | input | 1 | Skip test on the external flag, sampled at cycle end |
| tst_tmr | input | 1 | Skip test on the timer flag, sampled at cycle end |
| ctrl_wr | input | 1 | Control register write strobe |
| acc_wdata | input | 4 | Accumulator value to write |
| ctrl_rdata | output | 4 | Control register readback |
| tmr_run | output | 1 | Prescaler and timer run control |
| tout_sel | output | 1 | Shared pin drives the timer output |
| vec_req | output | 1 | Vector request pulse |
| vec_src | output | 1 | Source of the request: 0 external, 1 timer |
| skip_ext | output | 1 | External skip-test result |
| skip_tmr | output | 1 | Timer skip-test result |

## Verification
The bench measures acceptance latency in two ways.

- **Flag pending before enable:** the flag is raised first and the global enable is set afterwards. This is done with the long-instruction flag low and then high, which separates the two- and three-cycle cases.
- **Strobe arriving mid-cycle with interrupts on:** this shows whether the conditions are judged at the cycle-end edge rather than when the strobe arrives.

Three further patterns check gating and ordering:

- **Both sources pending together:** this tells priority from arrival order.
- **Pin pulses of four and five clocks:** these bracket the hold filter.
- **Disable issued after arming:** this shows whether a withdrawn condition cancels the request while leaving the flag pending.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;
   typedef enum logic {
      SRC_EXT = 1'b0,
      SRC_TMR = 1'b1
   } irq_src_e;

   localparam int CTRL_W     = 4;
   localparam int BIT_EN_EXT = 0;
   localparam int BIT_EN_TMR = 1;
   localparam int BIT_RUN    = 2;
   localparam int BIT_TOUT   = 3;
endpackage

// File: rtl/irq_phase_gen.sv
module irq_phase_gen #(
   parameter int PHASES = 4
) (
   input  logic clk,
   input  logic rst_n,
   output logic first_ph,
   output logic last_ph
);
   localparam int PW = (PHASES > 1) ? $clog2(PHASES) : 1;

   if (PHASES < 2) begin : g_bad_phases
      $error("irq_phase_gen: PHASES must be at least 2");
   end

   logic [PW-1:0] ph_q;

   always_ff @(posedge clk) begin
      if (!rst_n)                       ph_q <= '0;
      else if (ph_q == PW'(PHASES - 1)) ph_q <= '0;
      else                              ph_q <= ph_q + 1'b1;
   end

   assign first_ph = (ph_q == '0);
   assign last_ph  = (ph_q == PW'(PHASES - 1));

   assert_phase_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
      last_ph |=> first_ph);
endmodule

// File: rtl/irq_pin_qual.sv
module irq_pin_qual #(
   parameter int SYNC_STAGES = 2,
   parameter int HOLD_CLKS   = 5,
   parameter bit ACTIVE_HIGH = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin,
   output logic hit
);
   localparam int CW = $clog2(HOLD_CLKS + 1);

   if (HOLD_CLKS < 1) begin : g_bad_hold
      $error("irq_pin_qual: HOLD_CLKS must be at least 1");
   end

   logic pin_act;
   logic lvl;
   assign pin_act = ACTIVE_HIGH ? pin : ~pin;

   if (SYNC_STAGES == 0) begin : g_nosync
      assign lvl = pin_act;
   end else begin : g_sync
      logic [SYNC_STAGES-1:0] sync_q;
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            sync_q <= '0;
         end else begin
            sync_q[0] <= pin_act;
            for (int i = 1; i < SYNC_STAGES; i++) sync_q[i] <= sync_q[i-1];
         end
      end
      assign lvl = sync_q[SYNC_STAGES-1];
   end

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n || !lvl)            cnt_q <= '0;
      else if (cnt_q != CW'(HOLD_CLKS)) cnt_q <= cnt_q + 1'b1;
   end

   assign hit = lvl && (cnt_q == CW'(HOLD_CLKS - 1));

   assert_hit_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
      hit |=> !hit);
endmodule

// File: rtl/irq_ctrl_reg.sv
module irq_ctrl_reg #(
   parameter int W = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr,
   input  logic [W-1:0] wdata,
   output logic [W-1:0] q
);
   if (W < 2) begin : g_bad_w
      $error("irq_ctrl_reg: W must hold both enable bits");
   end

   always_ff @(posedge clk) begin
      if (!rst_n)  q <= '0;
      else if (wr) q <= wdata;
   end

   assert_ctrl_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !wr |=> $stable(q));
endmodule

// File: rtl/irq_seq.sv
module irq_seq
   import irq_seq_pkg::*;
#(
   parameter int PHASES      = 4,
   parameter int HOLD_CLKS   = 5,
   parameter int SYNC_STAGES = 2,
   parameter bit ACTIVE_HIGH = 1'b1,
   parameter int LAT_SHORT   = 2,
   parameter int LAT_LONG    = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ext_pin,
   input  logic              tmr_uf,
   input  logic              multi_cyc,
   input  logic              ei_exec,
   input  logic              di_exec,
   input  logic              tst_ext,
   input  logic              tst_tmr,
   input  logic              ctrl_wr,
   input  logic [CTRL_W-1:0] acc_wdata,
   output logic [CTRL_W-1:0] ctrl_rdata,
   output logic              tmr_run,
   output logic              tout_sel,
   output logic              vec_req,
   output logic              vec_src,
   output logic              skip_ext,
   output logic              skip_tmr
);
   localparam int LW = $clog2(LAT_LONG + 1);

   if (LAT_SHORT < 1 || LAT_LONG < LAT_SHORT) begin : g_bad_lat
      $error("irq_seq: need 1 <= LAT_SHORT <= LAT_LONG");
   end

   logic ce, first_ph;
   irq_phase_gen #(.PHASES(PHASES)) u_phase (
      .clk(clk), .rst_n(rst_n), .first_ph(first_ph), .last_ph(ce));

   logic ext_hit;
   irq_pin_qual #(.SYNC_STAGES(SYNC_STAGES), .HOLD_CLKS(HOLD_CLKS),
                  .ACTIVE_HIGH(ACTIVE_HIGH)) u_pin (
      .clk(clk), .rst_n(rst_n), .pin(ext_pin), .hit(ext_hit));

   logic [CTRL_W-1:0] ctrl_q;
   irq_ctrl_reg #(.W(CTRL_W)) u_ctrl (
      .clk(clk), .rst_n(rst_n), .wr(ctrl_wr), .wdata(acc_wdata), .q(ctrl_q));

   logic en_ext, en_tmr;
   assign en_ext     = ctrl_q[BIT_EN_EXT];
   assign en_tmr     = ctrl_q[BIT_EN_TMR];
   assign ctrl_rdata = ctrl_q;
   assign tmr_run    = ctrl_q[BIT_RUN];
   assign tout_sel   = ctrl_q[BIT_TOUT];

   logic f_ext, f_tmr, ie_q, ei_pend_q, armed_q, vec_req_q;
   logic [LW-1:0] rem_q;
   irq_src_e vec_src_q, sel_src;

   logic act_ext, act_tmr, cond, fire, clr_ext, clr_tmr;
   assign act_ext  = en_ext & f_ext;
   assign act_tmr  = en_tmr & f_tmr;
   assign cond     = ie_q & ~di_exec & (act_ext | act_tmr);
   assign fire     = ce & armed_q & cond & (rem_q == LW'(1));
   assign sel_src  = act_ext ? SRC_EXT : SRC_TMR;
   assign skip_ext = f_ext & ~en_ext;
   assign skip_tmr = f_tmr & ~en_tmr;
   assign clr_ext  = (fire & (sel_src == SRC_EXT)) | (ce & tst_ext & skip_ext);
   assign clr_tmr  = (fire & (sel_src == SRC_TMR)) | (ce & tst_tmr & skip_tmr);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         f_ext <= 1'b0;
         f_tmr <= 1'b0;
      end else begin
         f_ext <= (f_ext & ~clr_ext) | ext_hit;
         f_tmr <= (f_tmr & ~clr_tmr) | tmr_uf;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ie_q      <= 1'b0;
         ei_pend_q <= 1'b0;
      end else if (ce) begin
         ei_pend_q <= ei_exec & ~di_exec;
         if (fire || di_exec) ie_q <= 1'b0;
         else if (ei_pend_q)  ie_q <= 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         armed_q <= 1'b0;
         rem_q   <= '0;
      end else if (ce) begin
         if (!armed_q) begin
            if (cond) begin
               armed_q <= 1'b1;
               rem_q   <= multi_cyc ? LW'(LAT_LONG) : LW'(LAT_SHORT);
            end
         end else if (!cond || rem_q == LW'(1)) begin
            armed_q <= 1'b0;
         end else begin
            rem_q <= rem_q - 1'b1;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vec_req_q <= 1'b0;
         vec_src_q <= SRC_EXT;
      end else begin
         vec_req_q <= fire;
         if (fire) vec_src_q <= sel_src;
      end
   end

   assign vec_req = vec_req_q;
   assign vec_src = vec_src_q;

   assert_vec_needs_ie_R3: assert property (@(posedge clk) disable iff (!rst_n)
      vec_req_q |-> $past(ie_q));
   assert_vec_at_cycle_start_R4: assert property (@(posedge clk) disable iff (!rst_n)
      vec_req_q |-> first_ph);
   assert_arm_needs_ie_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(armed_q) |-> $past(ie_q));
   assert_ie_dropped_R6: assert property (@(posedge clk) disable iff (!rst_n)
      vec_req_q |-> (!ie_q && !armed_q));
   assert_vec_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
      vec_req_q |=> !vec_req_q);
   assert_ext_first_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (vec_req_q && vec_src_q == SRC_TMR) |-> !$past(en_ext && f_ext));
   assert_test_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (ce && tst_ext && en_ext && f_ext && !fire) |=> f_ext);
endmodule

// File: tb/irq_seq_tb.sv
`timescale 1ns/1ps
module irq_seq_tb;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ext_pin = 1'b0, tmr_uf = 1'b0, multi_cyc = 1'b0;
   logic ei_exec = 1'b0, di_exec = 1'b0, tst_ext = 1'b0, tst_tmr = 1'b0;
   logic ctrl_wr = 1'b0;
   logic [3:0] acc_wdata = 4'h0;
   logic [3:0] ctrl_rdata;
   logic tmr_run, tout_sel, vec_req, vec_src, skip_ext, skip_tmr;

   always #2 clk = ~clk;

   irq_seq u_dut (
      .clk(clk), .rst_n(rst_n), .ext_pin(ext_pin), .tmr_uf(tmr_uf),
      .multi_cyc(multi_cyc), .ei_exec(ei_exec), .di_exec(di_exec),
      .tst_ext(tst_ext), .tst_tmr(tst_tmr), .ctrl_wr(ctrl_wr),
      .acc_wdata(acc_wdata), .ctrl_rdata(ctrl_rdata), .tmr_run(tmr_run),
      .tout_sel(tout_sel), .vec_req(vec_req), .vec_src(vec_src),
      .skip_ext(skip_ext), .skip_tmr(skip_tmr));

   int n_run = 0, n_fail = 0;
   int tick = 0;
   bit done = 1'b0;
   int exp_tick[$];
   logic exp_src[$];

   always @(posedge clk) begin
      if (!rst_n) tick <= 0;
      else        tick <= tick + 1;
   end

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // scoreboard monitor
   always @(negedge clk) begin
      if (rst_n && vec_req) begin
         if (exp_tick.size() == 0) begin
            check(1'b0, "R3 unexpected vector", tick, -1);
         end else begin
            int et;
            logic es;
            et = exp_tick.pop_front();
            es = exp_src.pop_front();
            check(tick == et, "R4 vector timing", tick, et);
            check(vec_src == es, "R6 vector source", int'(vec_src), int'(es));
         end
      end
   end

   task automatic to_last_phase();
      do @(negedge clk); while (tick % 4 != 3);
   endtask

   task automatic ce_strobe(input int which, output int t);
      to_last_phase();
      case (which)
         0: ei_exec = 1'b1;
         1: di_exec = 1'b1;
         2: tst_ext = 1'b1;
         default: tst_tmr = 1'b1;
      endcase
      @(negedge clk);
      t = tick;
      ei_exec = 1'b0; di_exec = 1'b0; tst_ext = 1'b0; tst_tmr = 1'b0;
   endtask

   task automatic wr_ctrl(input logic [3:0] v);
      @(negedge clk);
      ctrl_wr = 1'b1; acc_wdata = v;
      @(negedge clk);
      ctrl_wr = 1'b0;
   endtask

   task automatic pin_hold(input int n);
      @(negedge clk);
      ext_pin = 1'b1;
      repeat (n) @(negedge clk);
      ext_pin = 1'b0;
      repeat (12) @(negedge clk);
   endtask

   task automatic tmr_pulse();
      @(negedge clk); tmr_uf = 1'b1;
      @(negedge clk); tmr_uf = 1'b0;
   endtask

   task automatic wait_mc(input int n);
      repeat (4 * n) @(negedge clk);
   endtask

   task automatic expect_vec(input int t, input logic src);
      exp_tick.push_back(t);
      exp_src.push_back(src);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_run++; n_fail++;
         $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      int t;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check(ctrl_rdata == 4'h0, "R1 ctrl", int'(ctrl_rdata), 0);
      check(!tmr_run && !tout_sel, "R1 run/tout", int'({tmr_run, tout_sel}), 0);
      check(!vec_req, "R1 vec_req", int'(vec_req), 0);
      check(!skip_ext && !skip_tmr, "R1 skips", int'({skip_ext, skip_tmr}), 0);

      // R2 control register
      wr_ctrl(4'b1100);
      @(negedge clk);
      check(ctrl_rdata == 4'b1100, "R2 readback", int'(ctrl_rdata), 12);
      check(tmr_run && tout_sel, "R2 run/tout", int'({tmr_run, tout_sel}), 3);
      wr_ctrl(4'b0000);
      @(negedge clk);
      check(ctrl_rdata == 4'b0000 && !tmr_run, "R2 clear", int'(ctrl_rdata), 0);

      // R8 hold filter
      pin_hold(4);
      check(!skip_ext, "R8 short pulse ignored", int'(skip_ext), 0);
      pin_hold(5);
      check(skip_ext, "R8 five clocks sets flag", int'(skip_ext), 1);
      // R9 skip invalid while enabled
      wr_ctrl(4'b0001);
      @(negedge clk);
      check(!skip_ext, "R9 skip masked when enabled", int'(skip_ext), 0);

      // R4 short latency, flag pending before EI (R5)
      ce_strobe(0, t);
      expect_vec(t + 4 * (2 + 2), 1'b0);
      wait_mc(8);
      check(exp_tick.size() == 0, "R4 short vector seen", exp_tick.size(), 0);
      // R6 global enable now off: new flag must not vector
      pin_hold(6);
      wait_mc(6);
      // R4 long latency
      multi_cyc = 1'b1;
      ce_strobe(0, t);
      expect_vec(t + 4 * (2 + 3), 1'b0);
      wait_mc(8);
      multi_cyc = 1'b0;
      check(exp_tick.size() == 0, "R4 long vector seen", exp_tick.size(), 0);
      wr_ctrl(4'b0000);
      @(negedge clk);
      check(!skip_ext, "R6 serviced flag cleared", int'(skip_ext), 0);

      // R7 priority, R12 timer strobe sets flag
      tmr_pulse();
      @(negedge clk);
      check(skip_tmr, "R12 timer flag set", int'(skip_tmr), 1);
      pin_hold(6);
      wr_ctrl(4'b0011);
      ce_strobe(0, t);
      expect_vec(t + 16, 1'b0);
      wait_mc(8);
      ce_strobe(0, t);
      expect_vec(t + 16, 1'b1);
      wait_mc(8);
      check(exp_tick.size() == 0, "R7 both vectors seen", exp_tick.size(), 0);

      // R12/R4 strobe mid-cycle with interrupts on
      wr_ctrl(4'b0010);
      ce_strobe(0, t);
      wait_mc(3);
      do @(negedge clk); while (tick % 4 != 1);
      tmr_uf = 1'b1;
      t = tick + 1;
      @(negedge clk);
      tmr_uf = 1'b0;
      expect_vec(4 * (t / 4 + 1) + 8, 1'b1);
      wait_mc(6);
      check(exp_tick.size() == 0, "R12 timer vector seen", exp_tick.size(), 0);

      // R11 withdraw after arming
      tmr_pulse();
      ce_strobe(0, t);
      repeat (8) @(negedge clk);
      ce_strobe(1, t);
      wait_mc(8);
      wr_ctrl(4'b0000);
      @(negedge clk);
      check(skip_tmr, "R11 flag still pending", int'(skip_tmr), 1);

      // R10 skip test clears only when valid
      ce_strobe(3, t);
      @(negedge clk);
      check(!skip_tmr, "R10 valid test clears", int'(skip_tmr), 0);
      wr_ctrl(4'b0001);
      pin_hold(6);
      ce_strobe(2, t);
      wr_ctrl(4'b0000);
      @(negedge clk);
      check(skip_ext, "R10 test ignored while enabled", int'(skip_ext), 1);
      ce_strobe(2, t);
      @(negedge clk);
      check(!skip_ext, "R10 test clears when disabled", int'(skip_ext), 0);

      wait_mc(4);
      check(exp_tick.size() == 0, "R3 no missing vectors", exp_tick.size(), 0);
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule